// File: doc/BRIEF.md
# Seven-Pin Bidirectional GPIO Port

This block is a small general-purpose I/O port that sits on an 8-bit memory-mapped register bus. It has three registers: an output latch, a direction mask that sets each pin as input or output, and a pull-up mask. From these it drives three per-pin control vectors toward the pad ring: output enable, output value and pull-up enable. It also takes back the pin levels from the pads.

Software sets each pin as an input or an output by writing the direction register. When it reads the data address, each bit of the result comes from one of two places. For an output pin it is the latch. For an input pin it is the pin level, which passes through a two-stage synchronizer first. The latch can be written at any time. This lets software preload a value before it turns a pin into an output, so the pin never drives a stale level.

The bus is single-cycle. A write commits on the rising clock edge while `bus_req_i` and `bus_we_i` are high. Read data is combinational from the address while `bus_req_i` is high, and is zero otherwise.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch, the direction register and the pull-up register are all 0. `pad_oe_o`, `pad_out_o` and `pad_pu_o` are all 0.
- R2: Address 0x06 holds the direction register. A write stores bits 6..0, and a read returns exactly those bits with bit 7 as 0.
- R3: A pin whose direction bit is 1 has its `pad_oe_o` bit set, and its `pad_out_o` bit equals its latch bit. A pin whose direction bit is 0 has `pad_oe_o` and `pad_out_o` both at 0.
- R4: A write to address 0x02 updates the latch whatever the direction bits are. For input pins, the new latch value changes neither the pads nor the value read back.
- R5: A read of address 0x02 returns, for each bit 6..0, the latch bit if that pin's direction bit is 1 and the synchronized pin level if it is 0. Bit 7 reads as 0.
- R6: A change on `pin_i` shows on a data read only after two rising clock edges, not after one.
- R7: Address 0x0C holds the pull-up register. A write stores bits 6..0, and a read returns exactly those bits with bit 7 as 0.
- R8: A `pad_pu_o` bit is 1 exactly when that pin's pull-up bit is 1 and its direction bit is 0.
- R9: An input pin whose pull-up bit is 0 is high-impedance: its `pad_oe_o` and `pad_pu_o` bits are both 0.
- R10: Reads of any other address return 0. Writes to any other address change no register.
- R11: In the first cycle after a write that changes a direction bit from 0 to 1, that pin drives the value already held in its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| pin_i | input | 7 | Pin levels from the pads |
| pad_oe_o | output | 7 | Per-pin output enable |
| pad_out_o | output | 7 | Per-pin output value |
| pad_pu_o | output | 7 | Per-pin pull-up enable |

## Verification
The data-read path is tried with all pins as inputs, all pins as outputs, and two mixed masks (0x55 and 0x2A). In each case the latch and the pin levels are set to opposite values, so every result bit shows which source it came from. Pull-up control is checked with the pull-up and direction masks overlapping only in part, which separates the bits where pull-up is asserted, suppressed by output mode, or off. The synchronizer is probed by reading one edge after a pin change and again after the second edge, and the direction-flip test preloads the latch so that the first driven value can be checked.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned PIN_N   = 7;
  localparam logic [BUS_W-1:0] ADDR_DATA = 8'h02;
  localparam logic [BUS_W-1:0] ADDR_DIR  = 8'h06;
  localparam logic [BUS_W-1:0] ADDR_PUE  = 8'h0C;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PUE  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_W-1:0] addr);
    unique case (addr)
      ADDR_DATA: decode_addr = SEL_DATA;
      ADDR_DIR:  decode_addr = SEL_DIR;
      ADDR_PUE:  decode_addr = SEL_PUE;
      default:   decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R6: output is input seen two edges earlier, once two post-reset edges passed
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      a_r6_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = PIN_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] pue_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      pue_o   <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_DATA: latch_o <= wdata_i;
        SEL_DIR:  dir_o   <= wdata_i;
        SEL_PUE:  pue_o   <= wdata_i;
        default: ;
      endcase
    end
  end

  a_r4_latch_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_DATA) |=> (latch_o == $past(wdata_i)));
  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_DIR) |=> (dir_o == $past(wdata_i)));
  a_r7_pue_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_PUE) |=> (pue_o == $past(wdata_i)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || sel_i == SEL_NONE) |=> ($stable(latch_o) && $stable(dir_o) && $stable(pue_o)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned WIDTH = 7
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pue_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] rd_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign oe_o[i]  = dir_i[i];
    assign out_o[i] = dir_i[i] & latch_i[i];
    assign pu_o[i]  = pue_i[i] & ~dir_i[i];
    assign rd_o[i]  = dir_i[i] ? latch_i[i] : pin_sync_i[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic [PIN_N-1:0] pin_i,
  output logic [PIN_N-1:0] pad_oe_o,
  output logic [PIN_N-1:0] pad_out_o,
  output logic [PIN_N-1:0] pad_pu_o
);
  localparam int unsigned PAD_W = BUS_W - PIN_N;

  reg_sel_e         sel;
  logic             wr_en;
  logic [PIN_N-1:0] latch_q, dir_q, pue_q, pin_sync, data_rd;

  assign sel   = decode_addr(bus_addr_i);
  assign wr_en = bus_req_i & bus_we_i;

  gpio_sync #(.WIDTH(PIN_N), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_regs #(.WIDTH(PIN_N)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .sel_i(sel),
    .wdata_i(bus_wdata_i[PIN_N-1:0]),
    .latch_o(latch_q), .dir_o(dir_q), .pue_o(pue_q)
  );

  gpio_pad_ctl #(.WIDTH(PIN_N)) u_pad (
    .latch_i(latch_q), .dir_i(dir_q), .pue_i(pue_q), .pin_sync_i(pin_sync),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o), .rd_o(data_rd)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      unique case (sel)
        SEL_DATA: bus_rdata_o = {{PAD_W{1'b0}}, data_rd};
        SEL_DIR:  bus_rdata_o = {{PAD_W{1'b0}}, dir_q};
        SEL_PUE:  bus_rdata_o = {{PAD_W{1'b0}}, pue_q};
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  a_r9_no_pull_on_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_pu_o) == '0);
  a_r11_drive_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sel == SEL_DIR) |=> ((pad_out_o & pad_oe_o) == (latch_q & pad_oe_o)));
  a_r5_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[BUS_W-1] == 1'b0);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic [6:0] pin_i = '0, pad_oe_o, pad_out_o, pad_pu_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_port dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_req_i = 0;
  endtask

  task automatic set_pins(input logic [6:0] p);
    @(negedge clk_i); pin_i = p;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe", {1'b0, pad_oe_o}, 8'h00);
    check("R1 out", {1'b0, pad_out_o}, 8'h00);
    check("R1 pu", {1'b0, pad_pu_o}, 8'h00);
    rd(8'h06, d); check("R1 dir", d, 8'h00);
    rd(8'h0C, d); check("R1 pue", d, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr(8'h06, 8'hFF); rd(8'h06, d); check("R2 dir readback bit7", d, 8'h7F);
    wr(8'h06, 8'h35); rd(8'h06, d); check("R2 dir readback", d, 8'h35);
    wr(8'h06, 8'h00);
  endtask

  task automatic t_latch_inputs();
    logic [7:0] d;
    set_pins(7'h0F);
    wr(8'h02, 8'h70);
    check("R4 oe unchanged", {1'b0, pad_oe_o}, 8'h00);
    check("R4 out unchanged", {1'b0, pad_out_o}, 8'h00);
    rd(8'h02, d); check("R4 read pins not latch", d, 8'h0F);
    wr(8'h06, 8'h7F);
    rd(8'h02, d); check("R4 latch held", d, 8'h70);
    check("R3 oe", {1'b0, pad_oe_o}, 8'h7F);
    check("R3 out", {1'b0, pad_out_o}, 8'h70);
    wr(8'h06, 8'h00);
  endtask

  task automatic t_mixed(input logic [6:0] dir, input logic [6:0] lat, input logic [6:0] pins);
    logic [7:0] d;
    wr(8'h02, {1'b0, lat});
    wr(8'h06, {1'b0, dir});
    set_pins(pins);
    rd(8'h02, d);
    check("R5 mixed read", d, {1'b0, (dir & lat) | (~dir & pins)});
    check("R3 out mixed", {1'b0, pad_out_o}, {1'b0, dir & lat});
  endtask

  task automatic t_sync();
    logic [7:0] d;
    wr(8'h06, 8'h00);
    set_pins(7'h00);
    @(negedge clk_i); pin_i = 7'h5A;
    @(negedge clk_i); rd(8'h02, d); check("R6 after one edge", d, 8'h00);
    @(negedge clk_i); rd(8'h02, d); check("R6 after two edges", d, 8'h5A);
  endtask

  task automatic t_pull();
    logic [7:0] d;
    wr(8'h0C, 8'hFF); rd(8'h0C, d); check("R7 pue readback", d, 8'h7F);
    wr(8'h0C, 8'h3C);
    wr(8'h06, 8'h0F);
    check("R8 pu", {1'b0, pad_pu_o}, 8'h30);
    check("R9 hiz oe", {1'b0, pad_oe_o & ~7'h3C & ~7'h0F}, 8'h00);
    check("R9 hiz pu", {1'b0, pad_pu_o & 7'h43}, 8'h00);
    wr(8'h06, 8'h00);
    check("R8 all inputs", {1'b0, pad_pu_o}, 8'h3C);
    wr(8'h0C, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(8'h06, 8'h11); wr(8'h0C, 8'h22); wr(8'h02, 8'h33);
    wr(8'h03, 8'h7F); wr(8'h07, 8'h7F); wr(8'h0D, 8'h7F);
    rd(8'h03, d); check("R10 unmapped read", d, 8'h00);
    rd(8'h06, d); check("R10 dir kept", d, 8'h11);
    rd(8'h0C, d); check("R10 pue kept", d, 8'h22);
    check("R10 out kept", {1'b0, pad_out_o}, 8'h11);
    wr(8'h06, 8'h00); wr(8'h0C, 8'h00);
  endtask

  task automatic t_flip();
    wr(8'h02, 8'h2B);
    check("R11 before flip", {1'b0, pad_oe_o}, 8'h00);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = 8'h06; bus_wdata_i = 8'h7F;
    @(posedge clk_i); #1;
    check("R11 first oe", {1'b0, pad_oe_o}, 8'h7F);
    check("R11 first out", {1'b0, pad_out_o}, 8'h2B);
    @(negedge clk_i); bus_req_i = 0; bus_we_i = 0;
  endtask

  initial begin
    #1 t_reset();
    #20 rst_ni = 1'b1;
    t_reset();
    t_dir();
    t_latch_inputs();
    t_mixed(7'h55, 7'h7F, 7'h00);
    t_mixed(7'h2A, 7'h00, 7'h7F);
    t_mixed(7'h7F, 7'h35, 7'h4A);
    t_mixed(7'h00, 7'h35, 7'h4A);
    t_sync();
    t_pull();
    t_unmapped();
    t_flip();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule